// File: doc/BRIEF.md
# MRU-Tour Victim Selector

This block holds the replacement state of one set of a highly associative last-level cache and names the way to evict on a miss. It does not keep a full recency stack. For each way it keeps a small saturating count of "MRU tours". A tour is one occasion on which the block moved into the most-recently-used position while it was resident. A block with only one tour has shown no reuse since it was filled, so it is the preferred victim. The current MRU way is always protected from eviction.

The cache controller reports each lookup on an access strobe, together with a hit flag and the hit way. It reports each line installation on a fill strobe, together with the filled way. The victim output is combinational from the present state, so it can be read in the same cycle as the miss. When several ways qualify, the victim is chosen pseudo-randomly. A free-running 16-bit LFSR supplies a rotating start index, and the selector takes the first qualifying way at or after that index, wrapping around. Tag storage, data storage and the miss sequence itself belong to the surrounding cache.

Top module: `mrut_victim_sel`

## Requirements
- R1: A synchronous active-low reset clears every tour count to 0 and makes way 0 the MRU way. From then on, until the first fill, the victim is never way 0.
- R2: A fill strobe sets the filled way's tour count to 1 and makes that way the MRU way. The effect is visible from the cycle after the strobe.
- R3: A hit to a way other than the MRU way adds one to that way's tour count and makes it the MRU way.
- R4: A hit to the way that is already MRU does not change any tour count or the MRU way.
- R5: An access strobe with the hit flag low leaves all state unchanged, whatever way number is presented with it.
- R6: When a fill and a hit arrive in the same cycle, the fill is applied and the hit is discarded.
- R7: The victim way is never the current MRU way.
- R8: If any way other than the MRU way has a tour count of exactly 1, the victim is one of those ways.
- R9: If no way other than the MRU way has a tour count of 1, the victim may be any way other than the MRU way.
- R10: The choice among qualifying ways is pseudo-random. A 16-bit maximal-length LFSR with taps 16,14,13,11 advances every cycle. Its low log2(ways) bits give a start index, and the first qualifying way at or after that index, wrapping around, is chosen. When several ways qualify, more than one of them is chosen over time.
- R11: The victim output is combinational. A state change made by a strobe is reflected in the victim in the cycle right after the strobe's clock edge.
- R12: A tour count saturates at 3 and never wraps back to 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | A lookup to this set occurs in this cycle |
| acc_hit | input | 1 | The lookup hit |
| acc_way | input | log2(NUM_WAYS) | Way that hit |
| fill_valid | input | 1 | A line is installed in this cycle |
| fill_way | input | log2(NUM_WAYS) | Way being installed |
| victim_way | output | log2(NUM_WAYS) | Way to evict on a miss |

## Verification
Every strobe takes effect at the clock edge on which it is sampled. The victim reflects the new state one half-cycle later, because it is combinational from the registers. The bench drives strobes on the falling edge and removes them just after the rising edge. It samples the victim on the following falling edge, so each check sees the state exactly one edge after the stimulus. The LFSR moves the start index on every edge. For that reason the checks are written either for states with a single qualifying way, where the result is fixed, or as membership and variety tests over a window of consecutive falling edges.

// File: rtl/mrut_pkg.sv
// Shared constants and the random-source step function for the MRU-tour
// victim selector. Assumes a 16-bit maximal-length feedback polynomial.
package mrut_pkg;
    localparam int TOUR_W = 2;
    localparam logic [TOUR_W-1:0] TOUR_ONE = 1;
    localparam logic [TOUR_W-1:0] TOUR_MAX = '1;
    localparam int RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;

    // One step of the Fibonacci LFSR, taps 16,14,13,11
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/mrut_rnd.sv
// Free-running pseudo-random source. Advances on every clock edge after
// reset and never reaches the all-zero lock-up state.
module mrut_rnd
    import mrut_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    // Advance the LFSR each cycle; reseed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= RND_SEED;
        else        rnd <= rnd_step(rnd);
    end

    assert_rnd_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);
endmodule

// File: rtl/mrut_tour_table.sv
// Per-way MRU-tour counters and the MRU pointer for one set.
// Assumes that at most one fill and one hit arrive per cycle; a fill wins.
module mrut_tour_table
    import mrut_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             hit_upd,
    input  logic [WAY_W-1:0]                 hit_way,
    input  logic                             fill_upd,
    input  logic [WAY_W-1:0]                 fill_way,
    output logic [NUM_WAYS-1:0][TOUR_W-1:0]  cnt,
    output logic [WAY_W-1:0]                 mru
);
    logic new_tour;
    // A hit starts a tour only when it moves the MRU position
    always_comb new_tour = hit_upd && (hit_way != mru);

    // Update counters and the MRU pointer on fill or tour-starting hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mru <= '0;
        end else if (fill_upd) begin
            cnt[fill_way] <= TOUR_ONE;
            mru           <= fill_way;
        end else if (new_tour) begin
            if (cnt[hit_way] != TOUR_MAX) cnt[hit_way] <= cnt[hit_way] + 1'b1;
            mru <= hit_way;
        end
    end

    assert_fill_sets_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_upd |=> (mru == $past(fill_way)) && (cnt[mru] == TOUR_ONE));
    assert_hit_moves_mru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_upd && !fill_upd) |=> (mru == $past(hit_way)));
    assert_mru_rehit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_upd && !fill_upd && hit_way == mru) |=> ($stable(cnt) && $stable(mru)));
    assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_upd && !fill_upd) |=> ($stable(cnt) && $stable(mru)));
    assert_count_saturates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (new_tour && !fill_upd && cnt[hit_way] == TOUR_MAX) |=> (cnt[mru] == TOUR_MAX));
endmodule

// File: rtl/mrut_pick.sv
// Rotating first-eligible picker: returns the first set bit of the mask at
// or after the start index, wrapping around. Assumes NUM_WAYS is a power of 2.
module mrut_pick #(
    parameter int NUM_WAYS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] elig,
    input  logic [WAY_W-1:0]    start,
    output logic [WAY_W-1:0]    sel
);
    logic [WAY_W-1:0] idx;
    // Scan offsets from far to near so the nearest eligible way wins
    always_comb begin
        sel = start;
        idx = start;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            idx = start + WAY_W'(i);
            if (elig[idx]) sel = idx;
        end
    end
endmodule

// File: rtl/mrut_victim_sel.sv
// MRU-tour victim selector for one cache set. Prefers unprotected ways with
// exactly one MRU tour, falls back to any unprotected way, and never names
// the current MRU way. The victim is combinational from registered state.
module mrut_victim_sel
    import mrut_pkg::*;
#(
    parameter int NUM_WAYS = 16,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             fill_valid,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] victim_way
);
    logic [NUM_WAYS-1:0][TOUR_W-1:0] cnt;
    logic [WAY_W-1:0]                mru;
    logic [RND_W-1:0]                rnd;
    logic [NUM_WAYS-1:0]             unprot;
    logic [NUM_WAYS-1:0]             single;
    logic [NUM_WAYS-1:0]             elig;

    mrut_rnd u_rnd (.clk(clk), .rst_n(rst_n), .rnd(rnd));

    mrut_tour_table #(.NUM_WAYS(NUM_WAYS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .hit_upd(acc_valid && acc_hit), .hit_way(acc_way),
        .fill_upd(fill_valid), .fill_way(fill_way),
        .cnt(cnt), .mru(mru)
    );

    // Build the protection and single-tour masks for every way
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_mask
        assign unprot[w] = (mru != WAY_W'(w));
        assign single[w] = unprot[w] && (cnt[w] == TOUR_ONE);
    end

    // Prefer single-tour ways; otherwise any unprotected way
    always_comb elig = (|single) ? single : unprot;

    mrut_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .elig(elig), .start(rnd[WAY_W-1:0]), .sel(victim_way)
    );

    assert_victim_not_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        victim_way != mru);
    assert_prefer_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|single) |-> (cnt[victim_way] == TOUR_ONE));
endmodule

// File: tb/mrut_victim_sel_test.sv
module mrut_victim_sel_test;
    localparam int NW = 16;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_hit = 1'b0, fill_valid = 1'b0;
    logic [WW-1:0] acc_way = '0, fill_way = '0;
    logic [WW-1:0] victim_way;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    mrut_victim_sel #(.NUM_WAYS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .fill_valid(fill_valid), .fill_way(fill_way),
        .victim_way(victim_way)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One strobe cycle; result is visible at the next falling edge
    task automatic strobe(input bit av, input bit ah, input int aw, input bit fv, input int fw);
        @(negedge clk);
        acc_valid = av; acc_hit = ah; acc_way = WW'(aw);
        fill_valid = fv; fill_way = WW'(fw);
        @(posedge clk);
        #1;
        acc_valid = 1'b0; acc_hit = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic hit(input int w);  strobe(1, 1, w, 0, 0); endtask
    task automatic fill(input int w); strobe(0, 0, 0, 1, w); endtask

    // Victim must equal one way over n consecutive samples
    task automatic hold_victim(input int w, input int n, input string req);
        int bad = 0, last = w;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (victim_way != WW'(w)) begin bad++; last = victim_way; end
        end
        check(bad == 0, req, last, w);
    endtask

    task automatic t_reset();
        int bad = 0, last = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (victim_way == 0) begin bad++; last = 0; end
        end
        check(bad == 0, "R1 victim avoids way 0 after reset", last, 1);
    endtask

    task automatic t_fill_all();
        bit [NW-1:0] seen = '0;
        int bad = 0;
        for (int w = 0; w < NW; w++) fill(w);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            seen[victim_way] = 1'b1;
            if (victim_way == 15) bad++;
        end
        check(bad == 0, "R2/R7 filled MRU way 15 never victim", bad, 0);
        check($countones(seen) >= 2, "R10 several candidates chosen", $countones(seen), 2);
    endtask

    task automatic t_single();
        for (int w = 0; w <= 13; w++) hit(w);
        hit(15);
        @(negedge clk);
        check(victim_way == 14, "R11 victim updated next cycle", victim_way, 14);
        hold_victim(14, 20, "R3/R8 only single-tour way 14 chosen");
    endtask

    task automatic t_rehit();
        fill(14);
        hit(14); hit(14); hit(14);
        hit(3);
        hold_victim(14, 12, "R4 rehit of MRU adds no tour");
    endtask

    task automatic t_saturate();
        bit outside = 1'b0;
        int bad = 0;
        hit(14);
        hit(4); hit(3); hit(4); hit(3); hit(4); hit(5);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (victim_way != 3 && victim_way != 4) outside = 1'b1;
            if (victim_way == 5) bad++;
        end
        check(outside, "R12/R9 saturated counts give fallback choice", outside, 1);
        check(bad == 0, "R7 MRU way 5 never victim", bad, 0);
    endtask

    task automatic t_miss();
        fill(8);
        hit(9);
        hold_victim(8, 8, "R8 single-tour way 8 chosen");
        strobe(1, 0, 8, 0, 0);
        hold_victim(8, 12, "R5 miss access changes nothing");
    endtask

    task automatic t_collide();
        strobe(1, 1, 10, 1, 7);
        hold_victim(8, 32, "R6 fill wins over same-cycle hit");
        hit(8);
        hold_victim(7, 12, "R3 hit moves MRU to way 8");
    endtask

    initial begin
        t_reset();
        t_fill_all();
        t_single();
        t_rehit();
        t_saturate();
        t_miss();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule